// File: doc/BRIEF.md
# Hysteretic Gain-Step Controller with Freeze

This block decides when a receiver front end should switch its amplifier into a reduced-gain state and when it may return to full gain. Each clock it samples a digital signal-strength code. A code at or above an upper threshold cuts the gain at once. Full gain comes back only after the code has stayed below a separate, lower threshold for an unbroken dwell period. The gap between the two thresholds absorbs the drop in measured strength that the gain step itself causes, so the loop does not oscillate.

Two asynchronous control inputs set the loop's mode: a power-enable input and a gain-control input. Both pass through two-flop synchronizers, and their edges are decoded against the power state:
- If the control input is high when power comes up, the loop starts disabled.
- A falling control edge while powered turns automatic operation on.
- A rising control edge while powered freezes the gain in whatever state it holds.
- While unpowered, the control input is ignored and the gain output stays at full gain.

Thresholds, code width and dwell length in clock cycles are parameters.

Top module: `agc_lock_ctrl`

## Requirements
- R1: After reset the mode output is 2'b00 (off) and the gain-cut output is 0.
- R2: In automatic mode (mode 2'b01) with gain-cut at 0, a strength code sampled at or above HI_CODE sets gain-cut to 1 at that same clock edge. A code of HI_CODE-1 does not set it.
- R3: In automatic mode with gain-cut at 1, gain-cut returns to 0 only after DWELL_CYC consecutive samples strictly below LO_CODE. Any sample at or above LO_CODE restarts the count from zero.
- R4: A code in the band from LO_CODE to HI_CODE-1 leaves gain-cut unchanged, whichever state it is in.
- R5: If the synchronized control input is high when power rises, the mode becomes 2'b10 (disabled), and gain-cut stays 0 regardless of strength.
- R6: A high-to-low control transition while powered sets the mode to 2'b01, and the automatic loop resumes.
- R7: A low-to-high control transition while powered sets the mode to 2'b11 (locked). Gain-cut then holds its present value, 0 or 1, regardless of strength.
- R8: While power is low, the mode is 2'b00 and gain-cut is 0, and changes on the control input have no effect on either output.
- R9: A change on either control input is reflected on the mode output after the third rising clock edge following the change, and not earlier.
- R10: The dwell count is cleared whenever the loop leaves automatic mode, so a release after re-entry needs a full dwell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strength is sampled on every rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en_i | input | 1 | Asynchronous power enable; high means powered |
| gain_ctl_i | input | 1 | Asynchronous gain-control input (low means automatic) |
| strength_i | input | CODE_W | Signal-strength code, larger means stronger |
| gain_cut_o | output | 1 | 1 selects reduced gain, 0 selects full gain |
| mode_o | output | 2 | 00 off, 01 automatic, 10 disabled, 11 locked |

## Verification
A strength sample takes effect on gain-cut at the same rising edge that samples it. The bench drives the code two nanoseconds after an edge and compares gain-cut two nanoseconds after the next edge. The dwell release is checked at the edge of the DWELL_CYC-th low sample, and also one edge before it, where gain-cut must still be 1. A control-pin change crosses two synchronizer flops and one edge-detect flop. The bench therefore reads the mode after two edges, expecting the old value, and again after the third edge, expecting the new one. In random strength runs the expected gain state comes from a bench model that is advanced once per edge with the sample just driven.

// File: rtl/agc_lock_pkg.sv
package agc_lock_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_AUTO = 2'b01,
        MODE_DIS  = 2'b10,
        MODE_LOCK = 2'b11
    } agc_mode_e;

    typedef struct packed {
        logic pwr;
        logic ctl;
    } ctl_pins_t;

    // Next loop mode from the current and previous synchronized pin levels.
    function automatic agc_mode_e next_mode(ctl_pins_t now, ctl_pins_t prev, agc_mode_e cur);
        agc_mode_e nxt;
        if (!now.pwr) begin
            nxt = MODE_OFF;
        end else if (!prev.pwr) begin
            nxt = now.ctl ? MODE_DIS : MODE_AUTO;
        end else if (now.ctl && !prev.ctl) begin
            nxt = MODE_LOCK;
        end else if (!now.ctl && prev.ctl) begin
            nxt = MODE_AUTO;
        end else begin
            nxt = cur;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/agc_sync2.sv
module agc_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/agc_mode_ctrl.sv
module agc_mode_ctrl
    import agc_lock_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ctl_pins_t pins_i,
    output agc_mode_e mode_d_o,
    output agc_mode_e mode_q_o
);
    ctl_pins_t prev_q;
    agc_mode_e mode_q;
    agc_mode_e mode_d;

    always_comb begin
        mode_d = next_mode(pins_i, prev_q, mode_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            mode_q <= MODE_OFF;
        end else begin
            prev_q <= pins_i;
            mode_q <= mode_d;
        end
    end

    assign mode_d_o = mode_d;
    assign mode_q_o = mode_q;
endmodule

// File: rtl/agc_gain_loop.sv
module agc_gain_loop
    import agc_lock_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int HI_CODE   = 200,
    parameter int LO_CODE   = 140,
    parameter int DWELL_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  agc_mode_e         mode_i,
    input  logic [CODE_W-1:0] strength_i,
    output logic              cut_o
);
    localparam int CNT_W = (DWELL_CYC > 1) ? $clog2(DWELL_CYC) : 1;
    localparam logic [CNT_W-1:0]  LAST = CNT_W'(DWELL_CYC - 1);
    localparam logic [CODE_W-1:0] HI   = CODE_W'(HI_CODE);
    localparam logic [CODE_W-1:0] LO   = CODE_W'(LO_CODE);

    logic             cut_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cut_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            unique case (mode_i)
                MODE_AUTO: begin
                    if (!cut_q) begin
                        cnt_q <= '0;
                        if (strength_i >= HI) cut_q <= 1'b1;
                    end else if (strength_i >= LO) begin
                        cnt_q <= '0;
                    end else if (cnt_q == LAST) begin
                        cnt_q <= '0;
                        cut_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                MODE_LOCK: begin
                    cnt_q <= '0;
                end
                default: begin
                    cnt_q <= '0;
                    cut_q <= 1'b0;
                end
            endcase
        end
    end

    assign cut_o = cut_q;
endmodule

// File: rtl/agc_lock_ctrl.sv
module agc_lock_ctrl
    import agc_lock_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int HI_CODE   = 200,
    parameter int LO_CODE   = 140,
    parameter int DWELL_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_en_i,
    input  logic              gain_ctl_i,
    input  logic [CODE_W-1:0] strength_i,
    output logic              gain_cut_o,
    output logic [1:0]        mode_o
);
    ctl_pins_t pins_async;
    ctl_pins_t pins_sync;
    agc_mode_e mode_d;
    agc_mode_e mode_q;

    assign pins_async = '{pwr: pwr_en_i, ctl: gain_ctl_i};

    agc_sync2 #(.W($bits(ctl_pins_t))) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pins_async),
        .q_o (pins_sync)
    );

    agc_mode_ctrl u_mode (
        .clk      (clk),
        .rst      (rst),
        .pins_i   (pins_sync),
        .mode_d_o (mode_d),
        .mode_q_o (mode_q)
    );

    agc_gain_loop #(
        .CODE_W    (CODE_W),
        .HI_CODE   (HI_CODE),
        .LO_CODE   (LO_CODE),
        .DWELL_CYC (DWELL_CYC)
    ) u_loop (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode_d),
        .strength_i (strength_i),
        .cut_o      (gain_cut_o)
    );

    assign mode_o = mode_q;
endmodule

// File: rtl/agc_lock_ctrl_sva.sv
module agc_lock_ctrl_sva
    import agc_lock_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int HI_CODE = 200,
    parameter int LO_CODE = 140
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] strength_i,
    input logic              gain_cut_o,
    input logic [1:0]        mode_o
);
    localparam logic [CODE_W-1:0] HI = CODE_W'(HI_CODE);
    localparam logic [CODE_W-1:0] LO = CODE_W'(LO_CODE);

    a_r2_cut_on_high: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_AUTO && !gain_cut_o && strength_i >= HI)
        |=> (gain_cut_o || mode_o != MODE_AUTO));

    a_r3_release_needs_low: assert property (@(posedge clk) disable iff (rst)
        ($fell(gain_cut_o) && mode_o == MODE_AUTO && $past(mode_o) == MODE_AUTO)
        |-> ($past(strength_i) < LO));

    a_r5_disabled_full_gain: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_DIS) |-> !gain_cut_o);

    a_r7_lock_holds_gain: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_LOCK && $past(mode_o) == MODE_LOCK) |-> $stable(gain_cut_o));

    a_r8_off_full_gain: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_OFF) |-> !gain_cut_o);

    a_r8_off_no_lock: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_OFF) |=> (mode_o != MODE_LOCK));
endmodule

bind agc_lock_ctrl agc_lock_ctrl_sva #(
    .CODE_W  (CODE_W),
    .HI_CODE (HI_CODE),
    .LO_CODE (LO_CODE)
) u_agc_lock_ctrl_sva (
    .clk        (clk),
    .rst        (rst),
    .strength_i (strength_i),
    .gain_cut_o (gain_cut_o),
    .mode_o     (mode_o)
);

// File: tb/agc_lock_ctrl_bench.sv
`timescale 1ns/1ps
module agc_lock_ctrl_bench;
    localparam int CW = 8;
    localparam int HI = 200;
    localparam int LO = 140;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr = 1'b0;
    logic          ctl = 1'b0;
    logic [CW-1:0] str = '0;
    logic          cut;
    logic [1:0]    mode;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // bench model of the automatic loop
    bit m_cut = 1'b0;
    int m_cnt = 0;

    always #5 clk = ~clk;

    agc_lock_ctrl #(
        .CODE_W (CW), .HI_CODE (HI), .LO_CODE (LO), .DWELL_CYC (DW)
    ) u_agc_lock_ctrl (
        .clk (clk), .rst (rst), .pwr_en_i (pwr), .gain_ctl_i (ctl),
        .strength_i (str), .gain_cut_o (cut), .mode_o (mode)
    );

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_step(int s);
        if (!m_cut) begin
            m_cnt = 0;
            if (s >= HI) m_cut = 1'b1;
        end else if (s >= LO) begin
            m_cnt = 0;
        end else if (m_cnt == DW - 1) begin
            m_cnt = 0;
            m_cut = 1'b0;
        end else begin
            m_cnt++;
        end
    endfunction

    task automatic ctl_change(bit p, bit c, int exp_old, int exp_new, string req);
        pwr = p;
        ctl = c;
        tick(2);
        chk(req, mode, exp_old);
        tick(1);
        chk(req, mode, exp_new);
    endtask

    initial begin
        void'($urandom(32'h1A2B_3C4D));
        tick(3);
        chk("R1 mode", mode, 0);
        chk("R1 cut", cut, 0);
        rst = 1'b0;
        tick(2);

        // R9 latency on power-up, ctl low -> automatic
        ctl_change(1'b1, 1'b0, 0, 1, "R9");

        // R2 / R4 thresholds
        str = 8'(LO + 10); tick(); chk("R4 mid no cut", cut, 0);
        str = 8'(HI - 1);  tick(); chk("R2 below hi", cut, 0);
        str = 8'(HI);      tick(); chk("R2 at hi", cut, 1);
        str = 8'(LO);      tick(20); chk("R4 mid hold cut", cut, 1);

        // R3 dwell with restart
        str = 8'(LO - 1); tick(DW - 1); chk("R3 before dwell", cut, 1);
        str = 8'(LO);     tick();       chk("R3 restart", cut, 1);
        str = 8'(LO - 1); tick(DW - 1); chk("R3 dwell-1", cut, 1);
        tick(); chk("R3 dwell done", cut, 0);

        // random strength runs against the model (R2 R3 R4)
        m_cut = 1'b0; m_cnt = 0;
        for (int seg = 0; seg < 200; seg++) begin
            int cat = $urandom % 4;
            int len = 1 + ($urandom % 24);
            for (int k = 0; k < len; k++) begin
                int s;
                case (cat)
                    0: s = $urandom % LO;
                    1: s = LO + ($urandom % (HI - LO));
                    2: s = HI + ($urandom % (256 - HI));
                    default: s = (($urandom % 16) == 0) ? LO : ($urandom % LO);
                endcase
                str = 8'(s);
                tick();
                model_step(s);
                chk("R2/R3/R4 random", cut, m_cut);
            end
        end

        // freeze in reduced gain (R7), resume (R6, R10)
        str = 8'd255; tick(); chk("R2 cut before lock", cut, 1);
        ctl_change(1'b1, 1'b1, 1, 3, "R7 lock");
        str = 8'd0; tick(40); chk("R7 hold cut", cut, 1);
        ctl_change(1'b1, 1'b0, 3, 1, "R6 unlock");
        tick(DW - 2); chk("R10 full dwell needed", cut, 1);
        tick(1); chk("R10 released", cut, 0);

        // freeze in full gain (R7)
        ctl_change(1'b1, 1'b1, 1, 3, "R7 lock low");
        str = 8'd255; tick(20); chk("R7 hold full gain", cut, 0);
        ctl_change(1'b1, 1'b0, 3, 1, "R6 auto again");
        chk("R2 cut on resume", cut, 1);

        // power-down (R8)
        ctl_change(1'b0, 1'b0, 1, 0, "R8 power down");
        chk("R8 cut cleared", cut, 0);
        ctl = 1'b1; tick(5); chk("R8 ctl rise ignored", mode, 0);
        chk("R8 cut stays", cut, 0);
        ctl = 1'b0; tick(5); chk("R8 ctl fall ignored", mode, 0);

        // power-up with ctl high (R5)
        ctl = 1'b1; tick(4);
        ctl_change(1'b1, 1'b1, 0, 2, "R5 disabled");
        str = 8'd255; tick(10); chk("R5 no cut", cut, 0);
        ctl_change(1'b1, 1'b0, 2, 1, "R6 enable");
        tick(); chk("R6 loop active", cut, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule